// File: doc/BRIEF.md
# Frame-Paced Coefficient Readback Sequencer

This block reads out a stored bank of filter coefficients one at a time. Each coefficient goes into the first output time slot of a time-division serial frame, one per frame. A decoded transmit control word comes in through `ctrl_load`. The word carries a mode bit, a two-bit RAM selector and a start bit. A rising start bit in data mode with a valid selector arms a readback. From the next frame boundary on, each `frame_sync` pulse loads the next coefficient of the chosen RAM into `slot_data`. The serial shifter that sends the slot out runs in the frame clock domain of the wider design. It takes the slot every frame.

The slot is a plain register with no valid/ready handshake. Pacing comes from `frame_sync` alone. The downstream shifter cannot apply back-pressure, because the frame does not wait. The slot value holds steady between frame pulses. Three coefficient RAMs are modelled as synchronous arrays. They are filled through a plain write port.

Top module: `coef_readback_seq`

## Requirements
- R1: A start edge loaded with `mode_sel`=1 (control mode) starts no readback: `busy` stays 0 and later frames carry 0.
- R2: `ram_sel` values 0, 1 and 2 pick RAM 0, 1 or 2. The selector is captured at the start edge.
- R3: A readback outputs 38 coefficients in address order 0..37. Each 13-bit coefficient sits in bits 15:3 of `slot_data`, and bits 2:0 are 0.
- R4: `slot_data` changes only on the clock edge where `frame_sync` is high. Each frame pulse advances by exactly one coefficient.
- R5: A start edge is a control load with `start_bit`=1 where the previous load had `start_bit`=0; the history is 0 after reset. Loading 1 again while it is already 1 starts nothing.
- R6: The first coefficient is loaded at the first `frame_sync` strictly after the load cycle that carried the start edge. That is one frame after the frame of the edge.
- R7: At the 38th load the sequencer goes idle. Every later frame pulse loads 0 until a new start.
- R8: A start edge in data mode with `ram_sel`=3 starts no readback and sets `sel_err`. `sel_err` stays set until reset.
- R9: A start edge while `busy` is high is ignored. The running sequence continues unchanged, and `sel_err` is unaffected.
- R10: `busy` rises on the clock after the accepted start edge. It falls on the clock after the frame pulse that loads the 38th coefficient.
- R11: After reset, `slot_data`=0, `busy`=0 and `sel_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle pulse at each frame boundary (frames at least 3 cycles apart) |
| ctrl_load | input | 1 | Strobe: control word fields valid this cycle |
| mode_sel | input | 1 | 0 = data mode, 1 = control mode |
| ram_sel | input | 2 | Coefficient RAM selector (3 is invalid) |
| start_bit | input | 1 | Start bit of the control word |
| wr_en | input | 1 | Coefficient RAM write strobe |
| wr_ram | input | 2 | RAM to write |
| wr_addr | input | 6 | Coefficient address to write (values of 38 or more are dropped) |
| wr_data | input | 13 | Coefficient value to write |
| slot_data | output | 16 | First output time slot contents |
| busy | output | 1 | Readback in progress |
| sel_err | output | 1 | Sticky invalid-selector flag |

## Verification
The hardest case to reach is a second start edge that arrives mid-sequence. It must be a genuine edge, not a held level, and it names a different RAM. To produce it, the bench loads a 0 and then a 1 partway through a readback of RAM 1, selecting RAM 0. It then checks that the remaining coefficients still come from RAM 1 at the expected addresses. Each of the three RAMs holds arithmetically distinct patterns, so a wrong RAM, a wrong address or an off-by-one frame shows up in every remaining slot.

// File: rtl/coef_rb_pkg.sv
package coef_rb_pkg;
  typedef enum logic {RB_IDLE = 1'b0, RB_RUN = 1'b1} rb_state_t;
endpackage

// File: rtl/coef_ram_bank.sv
module coef_ram_bank #(
  parameter int NUM_RAMS = 3,
  parameter int DEPTH    = 38,
  parameter int DW       = 13,
  parameter int AW       = 6,
  parameter int SW       = 2
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_ram,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [SW-1:0] rd_sel,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] bank_q [NUM_RAMS];

  for (genvar g = 0; g < NUM_RAMS; g++) begin : g_ram
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_ram) == g) && (int'(wr_addr) < DEPTH))
        mem[wr_addr] <= wr_data;
      if (int'(rd_addr) < DEPTH)
        bank_q[g] <= mem[rd_addr];
      else
        bank_q[g] <= '0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_RAMS; i++)
      if (int'(rd_sel) == i) rd_data = bank_q[i];
  end
endmodule

// File: rtl/rb_ctrl_decode.sv
module rb_ctrl_decode #(
  parameter int NUM_RAMS = 3,
  parameter int SW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_load,
  input  logic          mode_sel,
  input  logic [SW-1:0] ram_sel,
  input  logic          start_bit,
  input  logic          busy,
  output logic          launch,
  output logic          sel_err
);
  logic start_hist;
  logic start_rise;
  logic sel_ok;
  logic accept_window;

  assign start_rise    = ctrl_load && start_bit && !start_hist;
  assign sel_ok        = int'(ram_sel) < NUM_RAMS;
  assign accept_window = start_rise && !mode_sel && !busy;
  assign launch        = accept_window && sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_hist <= 1'b0;
      sel_err    <= 1'b0;
    end else begin
      if (ctrl_load) start_hist <= start_bit;
      if (accept_window && !sel_ok) sel_err <= 1'b1;
    end
  end
endmodule

// File: rtl/rb_sequencer.sv
module rb_sequencer
  import coef_rb_pkg::*;
#(
  parameter int DEPTH = 38,
  parameter int AW    = 6,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [SW-1:0] launch_sel,
  input  logic          frame_sync,
  output logic          busy,
  output logic [AW-1:0] rd_addr,
  output logic [SW-1:0] rd_sel,
  output logic          load_coef,
  output logic          load_zero
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  rb_state_t     state;
  logic [AW-1:0] idx;

  assign busy      = (state == RB_RUN);
  assign rd_addr   = idx;
  assign load_coef = frame_sync && (state == RB_RUN);
  assign load_zero = frame_sync && (state == RB_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RB_IDLE;
      idx    <= '0;
      rd_sel <= '0;
    end else begin
      unique case (state)
        RB_IDLE: begin
          idx <= '0;
          if (launch) begin
            state  <= RB_RUN;
            rd_sel <= launch_sel;
          end
        end
        RB_RUN: begin
          if (frame_sync) begin
            if (idx == LAST_IDX) begin
              state <= RB_IDLE;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= RB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rb_slot_loader.sv
module rb_slot_loader #(
  parameter int DW = 13,
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_coef,
  input  logic              load_zero,
  input  logic [DW-1:0]     coef,
  output logic [SLOT_W-1:0] slot
);
  localparam int PAD = SLOT_W - DW;

  logic [SLOT_W-1:0] aligned;

  if (PAD > 0) begin : g_pad
    assign aligned = {coef, {PAD{1'b0}}};
  end else begin : g_nopad
    assign aligned = coef[DW-1 -: SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         slot <= '0;
    else if (load_coef) slot <= aligned;
    else if (load_zero) slot <= '0;
  end
endmodule

// File: rtl/coef_readback_seq.sv
module coef_readback_seq #(
  parameter int NUM_RAMS = 3,
  parameter int DEPTH    = 38,
  parameter int DW       = 13,
  parameter int SLOT_W   = 16,
  parameter int SW       = 2,
  parameter int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              ctrl_load,
  input  logic              mode_sel,
  input  logic [SW-1:0]     ram_sel,
  input  logic              start_bit,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_ram,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [SLOT_W-1:0] slot_data,
  output logic              busy,
  output logic              sel_err
);
  logic          launch;
  logic [AW-1:0] rd_addr;
  logic [SW-1:0] rd_sel;
  logic [DW-1:0] rd_data;
  logic          load_coef;
  logic          load_zero;

  rb_ctrl_decode #(.NUM_RAMS(NUM_RAMS), .SW(SW)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctrl_load(ctrl_load), .mode_sel(mode_sel),
    .ram_sel(ram_sel), .start_bit(start_bit), .busy(busy),
    .launch(launch), .sel_err(sel_err)
  );

  rb_sequencer #(.DEPTH(DEPTH), .AW(AW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_sel(ram_sel),
    .frame_sync(frame_sync), .busy(busy), .rd_addr(rd_addr),
    .rd_sel(rd_sel), .load_coef(load_coef), .load_zero(load_zero)
  );

  coef_ram_bank #(.NUM_RAMS(NUM_RAMS), .DEPTH(DEPTH), .DW(DW), .AW(AW), .SW(SW)) u_bank (
    .clk(clk), .wr_en(wr_en), .wr_ram(wr_ram), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  rb_slot_loader #(.DW(DW), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load_coef(load_coef), .load_zero(load_zero),
    .coef(rd_data), .slot(slot_data)
  );
endmodule

// File: rtl/coef_readback_seq_chk.sv
module coef_readback_seq_chk #(
  parameter int SLOT_W = 16,
  parameter int SW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic              ctrl_load,
  input logic              mode_sel,
  input logic [SW-1:0]     ram_sel,
  input logic [SLOT_W-1:0] slot_data,
  input logic              busy,
  input logic              sel_err
);
  // R4: the slot holds between frame pulses
  assert_slot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(slot_data));

  // R7: an idle frame pulse clears the slot
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && !busy) |=> (slot_data == '0));

  // R8: the error flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err);

  // R1: busy never rises from a control-mode load
  assert_ctrl_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_load && mode_sel && !busy) |=> !busy);

  // R8: an invalid selector never starts a sequence
  assert_bad_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_load && (ram_sel == 2'd3) && !busy) |=> !busy);

  // R10: busy only rises after a control load
  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_load));

  // R10: busy only falls on a frame pulse
  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_sync));
endmodule

bind coef_readback_seq coef_readback_seq_chk #(.SLOT_W(SLOT_W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ctrl_load(ctrl_load),
  .mode_sel(mode_sel), .ram_sel(ram_sel), .slot_data(slot_data),
  .busy(busy), .sel_err(sel_err)
);

// File: tb/coef_readback_seq_tb.sv
module coef_readback_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic        ctrl_load = 1'b0;
  logic        mode_sel = 1'b0;
  logic [1:0]  ram_sel = '0;
  logic        start_bit = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ram = '0;
  logic [5:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [15:0] slot_data;
  logic        busy;
  logic        sel_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  coef_readback_seq u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ctrl_load(ctrl_load),
    .mode_sel(mode_sel), .ram_sel(ram_sel), .start_bit(start_bit),
    .wr_en(wr_en), .wr_ram(wr_ram), .wr_addr(wr_addr), .wr_data(wr_data),
    .slot_data(slot_data), .busy(busy), .sel_err(sel_err)
  );

  function automatic logic [12:0] pat(int r, int a);
    return 13'((r * 977 + a * 131 + 5 + r * a * 17) % 8192);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_ctrl(logic m, logic [1:0] r, logic s);
    @(negedge clk);
    mode_sel = m; ram_sel = r; start_bit = s; ctrl_load = 1'b1;
    @(negedge clk);
    ctrl_load = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic run_seq(int r, bit intrude);
    load_ctrl(1'b0, 2'(r), 1'b0);
    load_ctrl(1'b0, 2'(r), 1'b1);
    chk("R10 busy after edge", 32'(busy), 32'd1);
    chk("R6 slot before first frame", 32'(slot_data), 32'd0);
    for (int k = 0; k < 38; k++) begin
      if (intrude && k == 10) begin
        load_ctrl(1'b0, 2'd0, 1'b0);
        load_ctrl(1'b0, 2'd0, 1'b1);  // R9 ignored edge
        chk("R9 slot untouched by edge", 32'(slot_data), {16'd0, pat(r, k - 1), 3'b000});
      end
      frame();
      chk(k == 0 ? "R6 first coef" : "R3 R2 coef", 32'(slot_data), {16'd0, pat(r, k), 3'b000});
      chk("R10 busy during", 32'(busy), (k == 37) ? 32'd0 : 32'd1);
    end
    frame();
    chk("R7 zero after end", 32'(slot_data), 32'd0);
    frame();
    chk("R7 zero after end 2", 32'(slot_data), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 slot reset", 32'(slot_data), 32'd0);
    chk("R11 busy reset", 32'(busy), 32'd0);
    chk("R11 err reset", 32'(sel_err), 32'd0);
    for (int r = 0; r < 3; r++)
      for (int a = 0; a < 40; a++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_ram = 2'(r); wr_addr = 6'(a);
        wr_data = (a < 38) ? pat(r, a) : 13'h1FFF;
      end
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;
    frame();
    chk("R11 idle slot", 32'(slot_data), 32'd0);

    // R4: no change mid-frame
    run_seq(0, 1'b0);
    run_seq(1, 1'b1);
    chk("R9 no err from ignored edge", 32'(sel_err), 32'd0);
    run_seq(2, 1'b0);

    // R1 control mode
    load_ctrl(1'b1, 2'd0, 1'b0);
    load_ctrl(1'b1, 2'd0, 1'b1);
    chk("R1 busy stays low", 32'(busy), 32'd0);
    frame();
    chk("R1 slot zero", 32'(slot_data), 32'd0);

    // R5 held high: history is 1 now
    load_ctrl(1'b0, 2'd1, 1'b1);
    chk("R5 held high no start", 32'(busy), 32'd0);
    frame();
    chk("R5 slot zero", 32'(slot_data), 32'd0);

    // R8 invalid selector
    load_ctrl(1'b0, 2'd3, 1'b0);
    load_ctrl(1'b0, 2'd3, 1'b1);
    chk("R8 no start", 32'(busy), 32'd0);
    chk("R8 err set", 32'(sel_err), 32'd1);
    frame();
    chk("R8 slot zero", 32'(slot_data), 32'd0);
    run_seq(2, 1'b0);
    chk("R8 err sticky", 32'(sel_err), 32'd1);

    // R11 reset clears the flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 err cleared", 32'(sel_err), 32'd0);

    // R5 history cleared by reset: a fresh 1 is an edge
    load_ctrl(1'b0, 2'd0, 1'b1);
    chk("R5 edge after reset", 32'(busy), 32'd1);
    frame();
    chk("R2 ram0 coef0", 32'(slot_data), {16'd0, pat(0, 0), 3'b000});

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule